// File: doc/BRIEF.md
# Multi-Mode GPIO Port Register Block

This block is one general-purpose I/O port of up to 16 pins behind a simple memory-mapped register interface. Each pin can be an input, a push-pull output, an open-drain output, or a quasi-bidirectional pin. In quasi-bidirectional mode a low output is driven hard, and a rising output is driven high for a short boost before the pin falls back to a weak pull-up. The block drives a level, an enable and a pull-up request for every pad. It takes the pad input levels in through a two-flop synchroniser.

Software controls the port through these registers:
- a mode register with two bits per pin;
- an output data register whose writes are filtered by a write mask;
- an input-disable field that gates a pin's input path to zero;
- a read-only pin-level register.

Each pin also has a word alias, so that a single access reads that pin's level or sets that pin's output. The number of implemented pins and the port index are parameters. Bits for pins that are not implemented read as zero.

The bus is a single-cycle interface. A write is taken on the rising clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational from `bus_addr` while `bus_sel` is high and `bus_wr` is low.

Top module: `gpio_port`

## Requirements
- R1: During and after reset every mode field, output data bit, mask bit and input-disable bit is 0, every pad enable and pull-up request is 0, and every register reads 0.
- R2: A pin whose 2-bit mode field is 0 (input) has pad enable 0, pad level 0 and pull-up 0.
- R3: A pin whose mode is 1 (push-pull) has pad enable 1, pad level equal to its output data bit and pull-up 0.
- R4: A pin whose mode is 2 (open-drain) has pad level 0 and pull-up 0, with the pad enabled exactly when its output data bit is 0.
- R5: A pin whose mode is 3 (quasi-bidirectional) behaves as follows. With output bit 0 it drives low with the pad enabled. In the two clock cycles after its output bit changes from 0 to 1 it drives high with the pad enabled. After that it has pad enable 0, level 1 and pull-up 1. Rewriting a 1 over a 1 gives no new high-drive period.
- R6: A write to the output data register (offset 0x08, pin i at bit i) changes only the bits whose mask bit (offset 0x0C, pin i at bit i) is 0. Bits whose mask bit is 1 keep their value.
- R7: Input-disable bit 16+i at offset 0x04 forces pin i's level to 0, both in the pin-level register and in its alias read.
- R8: The pin-level register (offset 0x10, pin i at bit i) shows a pad input change on the second rising clock edge after the change. Before that edge it still shows the old value.
- R9: The alias of pin i sits at byte address ALIAS_BASE + 0x40*PORT_IDX + 4*i. A read returns the pin's level in bit 0 and zero in bits 31:1. A write copies bit 0 into output data bit i, ignores the mask and all other data bits, and leaves the other pins alone. Addresses in another port's alias window read 0.
- R10: Bits that belong to unimplemented pins read as 0 and cannot be set in any register.
- R11: The mode field of pin i is bits 2i+1:2i of offset 0x00. Reads of undecoded offsets return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| pad_in | input | NUM_PINS | Pad input levels |
| pad_out | output | NUM_PINS | Level driven onto each pad |
| pad_oe | output | NUM_PINS | Pad driver enable |
| pad_pu | output | NUM_PINS | Weak pull-up request |

## Verification
The bench uses a 12-pin instance with port index 1, so unimplemented bits and the alias window offset both show up in the results.

Each of the four modes is swept with several output patterns:
- all-zero and all-one patterns tell driven-low from released pins;
- alternating patterns catch pins swapped with their neighbours.

Other checks:
- Random old-value/mask/new-value triples separate masked bits from writable ones.
- A sequence of pad patterns, read back before and after the synchroniser delay, pins down the two-edge latency.
- Alias writes that carry ones in every bit but bit 0 show that the other data bits are ignored and that the mask does not apply.
- The quasi-bidirectional boost is checked on each cycle around the rising write, and again when a 1 is rewritten over a 1.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int MAX_PINS  = 16;
  localparam int BOOST_CYC = 2;

  typedef enum logic [1:0] {
    PM_IN    = 2'd0,
    PM_PUSH  = 2'd1,
    PM_OD    = 2'd2,
    PM_QUASI = 2'd3
  } pin_mode_e;

  typedef struct packed {
    logic lvl;
    logic en;
    logic pu;
  } pad_ctl_t;

  localparam logic [2:0] OFF_MODE = 3'd0;
  localparam logic [2:0] OFF_DOFF = 3'd1;
  localparam logic [2:0] OFF_DOUT = 3'd2;
  localparam logic [2:0] OFF_MASK = 3'd3;
  localparam logic [2:0] OFF_PIN  = 3'd4;

  // one bit per implemented pin
  function automatic logic [MAX_PINS-1:0] impl_mask(input int n);
    logic [MAX_PINS-1:0] m;
    for (int i = 0; i < MAX_PINS; i++) m[i] = (i < n);
    return m;
  endfunction

  // two bits per implemented pin
  function automatic logic [31:0] impl_mask2(input int n);
    logic [31:0] m;
    for (int i = 0; i < MAX_PINS; i++) m[2*i +: 2] = (i < n) ? 2'b11 : 2'b00;
    return m;
  endfunction

  // bits with keep=1 retain old value
  function automatic logic [MAX_PINS-1:0] merge_masked(
    input logic [MAX_PINS-1:0] old_v,
    input logic [MAX_PINS-1:0] new_v,
    input logic [MAX_PINS-1:0] keep);
    return (old_v & keep) | (new_v & ~keep);
  endfunction

  function automatic pad_ctl_t pad_ctl(input pin_mode_e m, input logic d,
                                       input logic boost);
    pad_ctl_t c;
    unique case (m)
      PM_IN:    c = '{lvl: 1'b0, en: 1'b0,          pu: 1'b0};
      PM_PUSH:  c = '{lvl: d,    en: 1'b1,          pu: 1'b0};
      PM_OD:    c = '{lvl: 1'b0, en: ~d,            pu: 1'b0};
      PM_QUASI: c = '{lvl: d,    en: ~d | boost,    pu: d & ~boost};
      default:  c = '{lvl: 1'b0, en: 1'b0,          pu: 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv
  import gpio_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pin_mode_e mode,
  input  logic      dout,
  output logic      boost,
  output logic      lvl,
  output logic      en,
  output logic      pu
);
  localparam int CW = $clog2(BOOST_CYC + 1);

  logic          dout_d;
  logic [CW-1:0] cnt;
  logic          rise;
  pad_ctl_t      ctl;

  assign rise  = dout & ~dout_d;
  assign boost = rise | (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_d <= 1'b0;
      cnt    <= '0;
    end else begin
      dout_d <= dout;
      if (!dout)            cnt <= '0;
      else if (rise)        cnt <= CW'(BOOST_CYC - 1);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end

  assign ctl = pad_ctl(mode, dout, boost);
  assign lvl = ctl.lvl;
  assign en  = ctl.en;
  assign pu  = ctl.pu;
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int PORT_IDX   = 0,
  parameter int ADDR_W     = 12,
  parameter int ALIAS_BASE = 'h800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [MAX_PINS-1:0] pin_level,
  output logic [31:0]         mode_q,
  output logic [MAX_PINS-1:0] dout_q,
  output logic [MAX_PINS-1:0] mask_q,
  output logic [MAX_PINS-1:0] doff_q,
  output logic                dout_wr,
  output logic                alias_wr
);
  localparam logic [MAX_PINS-1:0] IMPL  = impl_mask(NUM_PINS);
  localparam logic [31:0]         IMPL2 = impl_mask2(NUM_PINS);
  localparam logic [ADDR_W-1:0]   ALIAS_LO = ADDR_W'(ALIAS_BASE + 64 * PORT_IDX);

  logic                reg_hit;
  logic                alias_hit;
  logic [2:0]          off;
  logic [3:0]          pidx;
  logic                reg_wr;
  logic [MAX_PINS-1:0] dout_nxt;
  logic [MAX_PINS-1:0] pin_onehot;

  assign reg_hit   = (bus_addr[ADDR_W-1:5] == '0);
  assign alias_hit = (bus_addr[ADDR_W-1:6] == ALIAS_LO[ADDR_W-1:6]);
  assign off       = bus_addr[4:2];
  assign pidx      = bus_addr[5:2];
  assign reg_wr    = bus_sel & bus_wr & reg_hit;
  assign dout_wr   = reg_wr & (off == OFF_DOUT);
  assign alias_wr  = bus_sel & bus_wr & alias_hit;
  assign pin_onehot = (MAX_PINS'(1) << pidx) & IMPL;

  always_comb begin
    dout_nxt = dout_q;
    if (dout_wr)
      dout_nxt = merge_masked(dout_q, bus_wdata[MAX_PINS-1:0], mask_q) & IMPL;
    else if (alias_wr)
      dout_nxt = bus_wdata[0] ? (dout_q | pin_onehot) : (dout_q & ~pin_onehot);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      dout_q <= '0;
      mask_q <= '0;
      doff_q <= '0;
    end else begin
      dout_q <= dout_nxt;
      if (reg_wr) begin
        case (off)
          OFF_MODE: mode_q <= bus_wdata & IMPL2;
          OFF_DOFF: doff_q <= bus_wdata[31:16] & IMPL;
          OFF_MASK: mask_q <= bus_wdata[MAX_PINS-1:0] & IMPL;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (reg_hit) begin
        case (off)
          OFF_MODE: bus_rdata = mode_q;
          OFF_DOFF: bus_rdata = {doff_q, 16'h0};
          OFF_DOUT: bus_rdata = {16'h0, dout_q};
          OFF_MASK: bus_rdata = {16'h0, mask_q};
          OFF_PIN:  bus_rdata = {16'h0, pin_level};
          default:  bus_rdata = '0;
        endcase
      end else if (alias_hit) begin
        bus_rdata = {31'h0, pin_level[pidx]};
      end
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int NUM_PINS   = 16,
  parameter int PORT_IDX   = 0,
  parameter int ADDR_W     = 12,
  parameter int ALIAS_BASE = 'h800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_out,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_PINS-1:0] pad_pu
);
  localparam logic [MAX_PINS-1:0] IMPL = impl_mask(NUM_PINS);

  logic [MAX_PINS-1:0] pad_in_ext;
  logic [MAX_PINS-1:0] sync_q;
  logic [MAX_PINS-1:0] pin_level;
  logic [31:0]         mode_q;
  logic [MAX_PINS-1:0] dout_q;
  logic [MAX_PINS-1:0] mask_q;
  logic [MAX_PINS-1:0] doff_q;
  logic                dout_wr;
  logic                alias_wr;
  logic [NUM_PINS-1:0] boost;

  generate
    if (NUM_PINS < MAX_PINS) begin : g_pad_ext
      assign pad_in_ext = {{(MAX_PINS - NUM_PINS){1'b0}}, pad_in};
    end else begin : g_pad_full
      assign pad_in_ext = pad_in;
    end
  endgenerate

  gpio_sync #(.W(MAX_PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in_ext),
    .q    (sync_q)
  );

  assign pin_level = sync_q & ~doff_q & IMPL;

  gpio_regs #(
    .NUM_PINS  (NUM_PINS),
    .PORT_IDX  (PORT_IDX),
    .ADDR_W    (ADDR_W),
    .ALIAS_BASE(ALIAS_BASE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pin_level(pin_level),
    .mode_q   (mode_q),
    .dout_q   (dout_q),
    .mask_q   (mask_q),
    .doff_q   (doff_q),
    .dout_wr  (dout_wr),
    .alias_wr (alias_wr)
  );

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      gpio_pin_drv u_drv (
        .clk  (clk),
        .rst_n(rst_n),
        .mode (pin_mode_e'(mode_q[2*i +: 2])),
        .dout (dout_q[i]),
        .boost(boost[i]),
        .lvl  (pad_out[i]),
        .en   (pad_oe[i]),
        .pu   (pad_pu[i])
      );
    end
  endgenerate
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int N = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic [N-1:0] pad_out,
  input logic [N-1:0] pad_oe,
  input logic [N-1:0] pad_pu,
  input logic [31:0] mode_q,
  input logic [15:0] dout_q,
  input logic [15:0] mask_q,
  input logic        dout_wr
);
  // R1: pads released after reset is applied
  a_r1_reset_release: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0) && (pad_pu == '0));

  // R6: masked bits survive a data register write
  a_r6_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    dout_wr |=> ((dout_q ^ $past(dout_q)) & $past(mask_q)) == 16'h0);

  generate
    for (genvar i = 0; i < N; i++) begin : g_pin
      logic [1:0] m;
      assign m = mode_q[2*i +: 2];

      a_r2_input_off: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'd0) |-> (!pad_oe[i] && !pad_pu[i] && !pad_out[i]));

      a_r3_push_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'd1) |-> (pad_oe[i] && (pad_out[i] == dout_q[i]) && !pad_pu[i]));

      a_r4_od_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'd2) |-> (!pad_out[i] && (pad_oe[i] == !dout_q[i]) && !pad_pu[i]));

      a_r5_quasi_low: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'd3 && !dout_q[i]) |-> (pad_oe[i] && !pad_out[i]));

      a_r5_quasi_boost: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'd3 && dout_q[i] && !$past(dout_q[i])) |->
        (pad_oe[i] && pad_out[i] && !pad_pu[i]));

      a_r5_quasi_release: assert property (@(posedge clk) disable iff (!rst_n)
        (m == 2'd3 && dout_q[i] && $past(dout_q[i]) && $past(dout_q[i], 2)) |->
        (!pad_oe[i] && pad_pu[i]));
    end
  endgenerate
endmodule

bind gpio_port gpio_port_chk #(.N(NUM_PINS)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .pad_out(pad_out),
  .pad_oe (pad_oe),
  .pad_pu (pad_pu),
  .mode_q (mode_q),
  .dout_q (dout_q),
  .mask_q (mask_q),
  .dout_wr(dout_wr)
);

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  localparam int NP    = 12;
  localparam int PIDX  = 1;
  localparam logic [31:0] IM = 32'h0000_0FFF;
  localparam logic [11:0] ABASE = 12'h840;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pu;

  int vectors = 0;
  int fails = 0;
  logic [31:0] seed = 32'h1234_5678;

  always #4 clk = ~clk;

  gpio_port #(.NUM_PINS(NP), .PORT_IDX(PIDX), .ADDR_W(12), .ALIAS_BASE('h800)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] s);
    return s * 32'd1103515245 + 32'd12345;
  endfunction

  // steady-state pad triple per mode, restated from R2-R5
  function automatic logic [2:0] exp_pad(input int m, input logic d);
    case (m)
      0: return 3'b000;
      1: return {d, 1'b1, 1'b0};
      2: return {1'b0, ~d, 1'b0};
      default: return {d, ~d, d};
    endcase
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] v, o, m, w, e, p, prev;
    logic [NP-1:0] eo, ee, ep;
    repeat (3) @(negedge clk);
    chk("R1 oe in reset", {20'h0, pad_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 5; a++) rdchk("R1 reg reset", 12'(a * 4), 32'h0);
    chk("R1 oe after reset", {20'h0, pad_oe}, 32'h0);
    chk("R1 pu after reset", {20'h0, pad_pu}, 32'h0);

    // R10/R11 field layout and unimplemented bits
    wr(12'h000, 32'hFFFF_FFFF);
    rdchk("R10 mode unimpl", 12'h000, 32'h00FF_FFFF);
    wr(12'h000, 32'h1B1B_1B1B);
    rdchk("R11 mode readback", 12'h000, 32'h1B1B_1B1B & 32'h00FF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    rdchk("R11 undecoded read", 12'h014, 32'h0);
    rdchk("R11 undecoded write no effect", 12'h000, 32'h001B_1B1B);
    rdchk("R11 undecoded 1c", 12'h01C, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    rdchk("R10 doff unimpl", 12'h004, 32'h0FFF_0000);
    wr(12'h004, 32'h0);
    wr(12'h00C, 32'hFFFF_FFFF);
    rdchk("R10 mask unimpl", 12'h00C, 32'h0000_0FFF);
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'hFFFF_FFFF);
    rdchk("R10 dout unimpl", 12'h008, 32'h0000_0FFF);
    wr(12'h000, 32'h0);

    // R6 masked write sweep
    for (int k = 0; k < 16; k++) begin
      seed = nxt(seed); o = seed >> 8;
      seed = nxt(seed); m = seed >> 8;
      seed = nxt(seed); w = seed >> 8;
      wr(12'h00C, 32'h0);
      wr(12'h008, o);
      wr(12'h00C, m);
      wr(12'h008, w);
      e = ((o & m) | (w & ~m)) & IM;
      rdchk("R6 masked write", 12'h008, e);
    end
    wr(12'h00C, 32'h0);

    // R2..R5 steady pad drive per mode and pattern
    for (int md = 0; md < 4; md++) begin
      v = '0;
      for (int i = 0; i < 16; i++) v[2*i +: 2] = 2'(md);
      wr(12'h000, v);
      for (int k = 0; k < 4; k++) begin
        case (k)
          0: p = 32'h000;
          1: p = 32'hFFF;
          2: p = 32'h555;
          default: p = 32'hA3C;
        endcase
        wr(12'h008, p);
        repeat (3) @(negedge clk);
        for (int i = 0; i < NP; i++) begin
          logic [2:0] t;
          t = exp_pad(md, p[i]);
          eo[i] = t[2]; ee[i] = t[1]; ep[i] = t[0];
        end
        case (md)
          0: begin chk("R2 out", {20'h0, pad_out}, {20'h0, eo});
                   chk("R2 oe", {20'h0, pad_oe}, {20'h0, ee});
                   chk("R2 pu", {20'h0, pad_pu}, {20'h0, ep}); end
          1: begin chk("R3 out", {20'h0, pad_out}, {20'h0, eo});
                   chk("R3 oe", {20'h0, pad_oe}, {20'h0, ee});
                   chk("R3 pu", {20'h0, pad_pu}, {20'h0, ep}); end
          2: begin chk("R4 out", {20'h0, pad_out}, {20'h0, eo});
                   chk("R4 oe", {20'h0, pad_oe}, {20'h0, ee});
                   chk("R4 pu", {20'h0, pad_pu}, {20'h0, ep}); end
          default: begin chk("R5 out", {20'h0, pad_out}, {20'h0, eo});
                   chk("R5 oe", {20'h0, pad_oe}, {20'h0, ee});
                   chk("R5 pu", {20'h0, pad_pu}, {20'h0, ep}); end
        endcase
      end
    end

    // R5 boost timing (mode still quasi for all pins)
    wr(12'h008, 32'h0);
    repeat (3) @(negedge clk);
    wr(12'h008, 32'h005);
    chk("R5 boost c1 oe", {20'h0, pad_oe}, 32'hFFF);
    chk("R5 boost c1 out", {20'h0, pad_out}, 32'h005);
    chk("R5 boost c1 pu", {20'h0, pad_pu}, 32'h000);
    @(negedge clk);
    chk("R5 boost c2 oe", {20'h0, pad_oe}, 32'hFFF);
    chk("R5 boost c2 pu", {20'h0, pad_pu}, 32'h000);
    @(negedge clk);
    chk("R5 release oe", {20'h0, pad_oe}, 32'hFFA);
    chk("R5 release pu", {20'h0, pad_pu}, 32'h005);
    wr(12'h008, 32'h005);
    chk("R5 rewrite no boost", {20'h0, pad_oe}, 32'hFFA);
    wr(12'h000, 32'h0);

    // R8 synchroniser latency
    prev = '0;
    for (int k = 0; k < 8; k++) begin
      seed = nxt(seed); p = (seed >> 7) & IM;
      pad_in = NP'(p);
      rdchk("R8 before edges", 12'h010, prev);
      @(negedge clk);
      rdchk("R8 after one edge", 12'h010, prev);
      @(negedge clk);
      rdchk("R8 after two edges", 12'h010, p);
      prev = p;
    end

    // R7 input disable
    pad_in = NP'(12'hFFF);
    repeat (2) @(negedge clk);
    wr(12'h004, 32'h00A5_0000);
    rdchk("R7 pin reg gated", 12'h010, 32'hFFF & ~32'h0A5);
    rdchk("R7 alias gated", ABASE + 12'h000, 32'h0);
    rdchk("R7 alias open", ABASE + 12'h004, 32'h1);
    wr(12'h004, 32'h0);
    rdchk("R7 ungated", 12'h010, 32'hFFF);

    // R9 alias writes ignore mask and upper bits
    wr(12'h00C, 32'h0);
    wr(12'h008, 32'h0);
    wr(12'h00C, 32'hFFFF);
    for (int i = 0; i < 16; i++)
      wr(ABASE + 12'(4 * i), 32'hFFFF_FFFE | 32'(i % 2));
    rdchk("R9 alias write result", 12'h008, 32'hAAA);
    wr(12'h00C, 32'h0);

    // R9 alias reads
    pad_in = NP'(12'h5C3);
    repeat (2) @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      e = (i < NP) ? 32'((12'h5C3 >> i) & 1) : 32'h0;
      rdchk("R9 alias read", ABASE + 12'(4 * i), e);
    end
    rdchk("R9 other port window", 12'h800, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule